// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits behind a receive MAC and sees each incoming Ethernet frame one byte per accepted beat. It looks inside the frame for a wake pattern. The pattern is a synchronisation run of all-ones bytes followed by the station's own 48-bit address sent sixteen times in a row. When a frame that holds the pattern ends with a good CRC, the block sets a sticky status flag and raises a wake interrupt. Power management logic uses that interrupt to bring the system out of a low-power state.

A second, looser wake source sits beside the pattern matcher. Any good frame that the upstream address filter marks as matching sets a separate sticky flag. Each flag has its own enable, so software can run the strict pattern mode without the generic one. Software clears either flag by writing a one to its bit through a write-one-to-clear strobe.

Top module: `magic_wake_det`

## Requirements
- R1: With `magic_en` at 1, a frame containing six 0xFF bytes followed by sixteen back-to-back copies of the station address sets `magic_sts` at the end of frame. Address bytes are compared most significant first: `station_addr[47:40]` is the first byte on the wire. Station address bytes are assumed to differ from 0xFF.
- R2: Any number of arbitrary bytes may come before and after the pattern inside the frame, and it is still detected.
- R3: More than six 0xFF bytes in a row still form a valid sync. Any mismatching byte restarts the search. An 0xFF byte that breaks an address run counts as the first byte of a new sync run. Fifteen copies of the address, or five 0xFF bytes, are not enough.
- R4: Status is set only on the beat carrying `rx_eof` with `rx_valid`, and only when `rx_crc_ok` is 1 on that beat. A frame with a bad CRC sets nothing.
- R5: A valid beat with `rx_sof` discards all matcher progress, so a pattern split across two frames, including an aborted frame with no end marker, is not detected.
- R6: While `magic_en` is 0, no pattern sets `magic_sts`.
- R7: With `generic_en` at 1, a good frame with `rx_addr_match` at 1 on its end beat sets `match_sts` and leaves `magic_sts` alone. With `generic_en` at 0, or `rx_addr_match` at 0, `match_sts` is not set.
- R8: A cycle with `clr_we` at 1 clears `magic_sts` where `clr_wdata[0]` is 1 and clears `match_sts` where `clr_wdata[1]` is 1. Zero bits in `clr_wdata` leave their flag unchanged. Both flags hold their value until they are cleared.
- R9: If a flag is set and cleared in the same cycle, the set wins and the flag reads 1 afterwards.
- R10: `wake_irq` is 1 exactly while either flag is 1. After reset both flags and `wake_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_crc_ok | input | 1 | Frame CRC good, sampled on the end beat |
| rx_addr_match | input | 1 | Upstream address filter matched this frame, sampled on the end beat |
| rx_byte | input | 8 | Received byte |
| station_addr | input | 48 | Own station address, first wire byte in bits 47:40 |
| magic_en | input | 1 | Enable pattern wake |
| generic_en | input | 1 | Enable address-match wake |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 2 | Clear mask: bit 0 pattern flag, bit 1 match flag |
| magic_sts | output | 1 | Sticky pattern-wake flag |
| match_sts | output | 1 | Sticky address-match wake flag |
| wake_irq | output | 1 | Wake interrupt |

## Verification
A wrong count or byte index inside the matcher stays hidden until an end-of-frame beat. It then shows up in that same cycle as a missing or spurious rise of `magic_sts` and `wake_irq`. The bench therefore checks the flags one cycle after every frame. A bench search over the stored frame gives the expected result, so an off-by-one in the sync run, the repeat count or the overlap handling shows up in the first frame that reaches that boundary. Faults in the clear or set priority show up in the cycle after the write.

// File: rtl/mwd_pkg.sv
// Shared constants for the magic packet wake detector.
// Assumes a byte-wide receive stream and two wake flags.
package mwd_pkg;
    localparam int     MWD_ADDR_BYTES = 6;
    localparam int     MWD_SYNC_LEN   = 6;
    localparam int     MWD_REPEATS    = 16;
    localparam logic [7:0] MWD_SYNC_BYTE = 8'hFF;
    localparam int     ST_MAGIC = 0;
    localparam int     ST_MATCH = 1;
    localparam int     NUM_ST   = 2;
endpackage

// File: rtl/mwd_matcher.sv
// Byte-serial pattern matcher: counts a sync run of SYNC_BYTE, then the
// station address repeated REPEATS times. Assumes no address byte equals
// SYNC_BYTE. State clears on a start-of-frame beat or while disabled.
// hit_now reports a found pattern including the current beat.
module mwd_matcher
    import mwd_pkg::*;
#(
    parameter int ADDR_BYTES = MWD_ADDR_BYTES,
    parameter int SYNC_LEN   = MWD_SYNC_LEN,
    parameter int REPEATS    = MWD_REPEATS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    beat,
    input  logic                    sof,
    input  logic [7:0]              data,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    hit_now
);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;
    localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
    localparam logic [IW-1:0] IDX_LAST  = IW'(ADDR_BYTES - 1);
    localparam logic [RW-1:0] REP_LAST  = RW'(REPEATS - 1);

    logic [7:0]    addr_b [ADDR_BYTES];
    logic [SW-1:0] sync_q, sync_n;
    logic          in_addr_q, in_addr_n;
    logic [IW-1:0] idx_q, idx_n;
    logic [RW-1:0] rep_q, rep_n;
    logic          found_q, found_n;
    logic          step;

    // Split the station address into wire-order bytes.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
        assign addr_b[k] = station_addr[8*(ADDR_BYTES-1-k) +: 8];
    end

    // Next-state search logic for one beat.
    always_comb begin
        sync_n    = sync_q;
        in_addr_n = in_addr_q;
        idx_n     = idx_q;
        rep_n     = rep_q;
        found_n   = found_q;
        step      = 1'b0;
        if (beat && sof) begin
            sync_n    = '0;
            in_addr_n = 1'b0;
            idx_n     = '0;
            rep_n     = '0;
            found_n   = 1'b0;
        end
        if (beat && !found_n) begin
            if (!in_addr_n) begin
                if (data == MWD_SYNC_BYTE) begin
                    if (sync_n != SYNC_FULL) sync_n = sync_n + 1'b1;
                end else if (sync_n == SYNC_FULL && data == addr_b[0]) begin
                    in_addr_n = 1'b1;
                    idx_n     = '0;
                    rep_n     = '0;
                    step      = 1'b1;
                end else begin
                    sync_n = '0;
                end
            end else if (data == addr_b[idx_n]) begin
                step = 1'b1;
            end else begin
                in_addr_n = 1'b0;
                sync_n    = (data == MWD_SYNC_BYTE) ? SW'(1) : '0;
            end
            if (step) begin
                if (idx_n == IDX_LAST) begin
                    idx_n = '0;
                    if (rep_n == REP_LAST) found_n = 1'b1;
                    else                   rep_n   = rep_n + 1'b1;
                end else begin
                    idx_n = idx_n + 1'b1;
                end
            end
        end
        if (!enable) begin
            sync_n    = '0;
            in_addr_n = 1'b0;
            idx_n     = '0;
            rep_n     = '0;
            found_n   = 1'b0;
        end
    end

    // Matcher state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= '0;
            in_addr_q <= 1'b0;
            idx_q     <= '0;
            rep_q     <= '0;
            found_q   <= 1'b0;
        end else begin
            sync_q    <= sync_n;
            in_addr_q <= in_addr_n;
            idx_q     <= idx_n;
            rep_q     <= rep_n;
            found_q   <= found_n;
        end
    end

    assign hit_now = found_n;
endmodule

// File: rtl/mwd_sticky.sv
// One sticky status bit with write-one-to-clear; set has priority.
// Assumes set and clear are single-cycle requests.
module mwd_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, clear or set the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/magic_wake_det.sv
// Wake detector top: commits pattern and address-match wake events at a
// good end of frame into two sticky flags and drives the wake interrupt.
// Assumes rx_sof/rx_eof/rx_crc_ok/rx_addr_match are qualified by rx_valid.
module magic_wake_det
    import mwd_pkg::*;
#(
    parameter int ADDR_BYTES = MWD_ADDR_BYTES,
    parameter int SYNC_LEN   = MWD_SYNC_LEN,
    parameter int REPEATS    = MWD_REPEATS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_crc_ok,
    input  logic                    rx_addr_match,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    magic_en,
    input  logic                    generic_en,
    input  logic                    clr_we,
    input  logic [NUM_ST-1:0]       clr_wdata,
    output logic                    magic_sts,
    output logic                    match_sts,
    output logic                    wake_irq
);
    logic              hit_now;
    logic              commit;
    logic [NUM_ST-1:0] set_v, clr_v, sts_v;

    mwd_matcher #(
        .ADDR_BYTES(ADDR_BYTES),
        .SYNC_LEN  (SYNC_LEN),
        .REPEATS   (REPEATS)
    ) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (magic_en),
        .beat        (rx_valid),
        .sof         (rx_sof),
        .data        (rx_byte),
        .station_addr(station_addr),
        .hit_now     (hit_now)
    );

    // Good end-of-frame beat and per-flag set/clear requests.
    always_comb begin
        commit          = rx_valid & rx_eof & rx_crc_ok;
        set_v           = '0;
        set_v[ST_MAGIC] = commit & magic_en & hit_now;
        set_v[ST_MATCH] = commit & generic_en & rx_addr_match;
        clr_v           = clr_we ? clr_wdata : '0;
    end

    for (genvar s = 0; s < NUM_ST; s++) begin : g_sts
        mwd_sticky u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_v[s]),
            .clr  (clr_v[s]),
            .q    (sts_v[s])
        );
    end

    assign magic_sts = sts_v[ST_MAGIC];
    assign match_sts = sts_v[ST_MATCH];
    assign wake_irq  = |sts_v;
endmodule

// File: rtl/mwd_checker.sv
// Assertion checker for magic_wake_det, attached by bind below.
module mwd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_eof,
    input logic       rx_crc_ok,
    input logic       rx_addr_match,
    input logic       magic_en,
    input logic       generic_en,
    input logic       clr_we,
    input logic [1:0] clr_wdata,
    input logic       hit_now,
    input logic       magic_sts,
    input logic       match_sts,
    input logic       wake_irq
);
    logic good_end;
    assign good_end = rx_valid && rx_eof && rx_crc_ok;

    // R4: pattern flag rises only after a good end beat with enable.
    p_magic_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(magic_sts) |-> $past(good_end && magic_en));

    // R7: match flag rises only from an enabled address-match end beat.
    p_match_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_sts) |-> $past(good_end && generic_en && rx_addr_match));

    // R8: flag holds without a clear of its bit.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        magic_sts && !(clr_we && clr_wdata[0]) |=> magic_sts);

    // R8: clear without a concurrent set drops the flag.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_wdata[1] && !(good_end && generic_en && rx_addr_match) |=> !match_sts);

    // R9: a completed pattern at a good end always lands, clear or not.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        good_end && magic_en && hit_now |=> magic_sts);

    // R6: matcher reports nothing while disabled.
    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !magic_en |-> !hit_now);

    // R10: interrupt falls only through a clear write.
    p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_irq) |-> $past(clr_we));

    // R10: reset leaves the interrupt low.
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !wake_irq && !magic_sts && !match_sts);
endmodule

bind magic_wake_det mwd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_eof       (rx_eof),
    .rx_crc_ok    (rx_crc_ok),
    .rx_addr_match(rx_addr_match),
    .magic_en     (magic_en),
    .generic_en   (generic_en),
    .clr_we       (clr_we),
    .clr_wdata    (clr_wdata),
    .hit_now      (hit_now),
    .magic_sts    (magic_sts),
    .match_sts    (match_sts),
    .wake_irq     (wake_irq)
);

// File: tb/tb_magic_wake_det.sv
module tb_magic_wake_det;
    localparam int CLK_PERIOD = 10;
    localparam int MAXLEN     = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof, rx_crc_ok, rx_addr_match;
    logic [7:0]  rx_byte;
    logic [47:0] station_addr;
    logic        magic_en, generic_en, clr_we;
    logic [1:0]  clr_wdata;
    logic        magic_sts, match_sts, wake_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_m = 1'b0;
    logic exp_g = 1'b0;
    logic [7:0] fb [0:MAXLEN-1];
    int fl;

    always #(CLK_PERIOD/2) clk = ~clk;

    magic_wake_det dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_addr_match(rx_addr_match),
        .rx_byte(rx_byte), .station_addr(station_addr), .magic_en(magic_en),
        .generic_en(generic_en), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .magic_sts(magic_sts), .match_sts(match_sts), .wake_irq(wake_irq)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " magic_sts"}, magic_sts, exp_m);
        check({req, " match_sts"}, match_sts, exp_g);
        check({req, " wake_irq"}, wake_irq, exp_m | exp_g);
    endtask

    // Reference search: sync run then REPEATS address copies anywhere in frame.
    function automatic logic ref_detect(input int len);
        for (int i = 0; i + 102 <= len; i++) begin
            logic ok = 1'b1;
            for (int j = 0; j < 6; j++) if (fb[i+j] != 8'hFF) ok = 1'b0;
            for (int j = 0; j < 96; j++)
                if (fb[i+6+j] != station_addr[47-8*(j%6) -: 8]) ok = 1'b0;
            if (ok) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic put_byte(input logic [7:0] b);
        fb[fl] = b;
        fl++;
    endtask
    task automatic put_sync(input int n);
        for (int i = 0; i < n; i++) put_byte(8'hFF);
    endtask
    task automatic put_addr(input int reps);
        for (int r = 0; r < reps; r++)
            for (int k = 0; k < 6; k++) put_byte(station_addr[47-8*k -: 8]);
    endtask
    task automatic put_junk(input int n);
        for (int i = 0; i < n; i++) put_byte(8'($urandom_range(0, 255)));
    endtask

    // Send fb[0:fl-1]; optionally without end marker; optional clear on end beat.
    task automatic send_frame(input logic crc, input logic amatch, input logic with_eof,
                              input logic gaps, input logic [1:0] clr_at_end);
        for (int i = 0; i < fl; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
                rx_valid = 1'b0;
                rx_byte  = 8'hFF;
                @(negedge clk);
            end
            rx_valid      = 1'b1;
            rx_byte       = fb[i];
            rx_sof        = (i == 0);
            rx_eof        = with_eof && (i == fl - 1);
            rx_crc_ok     = crc;
            rx_addr_match = amatch;
            clr_we        = rx_eof && (clr_at_end != 2'b00);
            clr_wdata     = rx_eof ? clr_at_end : 2'b00;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
        rx_addr_match = 1'b0; clr_we = 1'b0; clr_wdata = 2'b00;
        if (with_eof) begin
            logic sm = crc && magic_en && ref_detect(fl);
            logic sg = crc && generic_en && amatch;
            exp_m = sm | (exp_m & ~clr_at_end[0]);
            exp_g = sg | (exp_g & ~clr_at_end[1]);
        end
        @(negedge clk);
    endtask

    task automatic do_clear(input logic [1:0] bits);
        clr_we = 1'b1;
        clr_wdata = bits;
        @(negedge clk);
        clr_we = 1'b0;
        clr_wdata = 2'b00;
        exp_m = exp_m & ~bits[0];
        exp_g = exp_g & ~bits[1];
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_crc_ok = 1'b0; rx_addr_match = 1'b0; rx_byte = 8'h00;
        station_addr = 48'h1122_3344_5566; magic_en = 1'b1; generic_en = 1'b0;
        clr_we = 1'b0; clr_wdata = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset");

        // R1: bare pattern, wire order first byte first.
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R1 bare pattern", magic_sts, 1'b1);
        check_all("R10 irq with flag");

        // R8: wrong bit and zero mask leave flag; own bit clears.
        do_clear(2'b10); check("R8 other bit", magic_sts, 1'b1);
        do_clear(2'b00); check("R8 zero mask", magic_sts, 1'b1);
        do_clear(2'b01); check("R8 own bit", magic_sts, 1'b0);
        check_all("R10 irq after clear");

        // R2: junk before and after.
        fl = 0; put_junk(20); put_sync(6); put_addr(16); put_junk(30);
        send_frame(1'b1, 1'b0, 1'b1, 1'b1, 2'b00);
        check("R2 surrounded", magic_sts, 1'b1);
        do_clear(2'b01);

        // R1 negative: reversed byte order is not the station address.
        station_addr = 48'h6655_4433_2211;
        fl = 0; station_addr = 48'h1122_3344_5566; put_sync(6);
        station_addr = 48'h6655_4433_2211; put_addr(16); station_addr = 48'h1122_3344_5566;
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R1 byte order", magic_sts, 1'b0);

        // R3: long sync run.
        fl = 0; put_sync(9); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R3 long sync", magic_sts, 1'b1);
        do_clear(2'b01);

        // R3: FF breaking the address run starts a new sync at one.
        fl = 0; put_sync(6); put_addr(3); put_byte(8'h11); put_byte(8'hFF);
        put_sync(5); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R3 overlap resync", magic_sts, 1'b1);
        do_clear(2'b01);

        // R3: fifteen copies, and a five-byte sync, do not match.
        fl = 0; put_sync(6); put_addr(15); put_byte(8'h00); put_junk(4);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R3 fifteen copies", magic_sts, 1'b0);
        fl = 0; put_sync(6); put_addr(2); put_byte(8'h00); put_sync(5); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R3 short sync", magic_sts, 1'b0);

        // R4: bad CRC.
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b0, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R4 bad crc", magic_sts, 1'b0);

        // R5: aborted frame without end, remainder in next frame.
        fl = 0; put_sync(6); put_addr(10);
        send_frame(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        fl = 0; put_addr(6);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R5 split frame", magic_sts, 1'b0);

        // R6: disabled.
        magic_en = 1'b0;
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b1, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R6 disabled", magic_sts, 1'b0);

        // R7: generic mode sets only its own flag.
        generic_en = 1'b1;
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R7 no addr match", match_sts, 1'b0);
        fl = 0; put_junk(40);
        send_frame(1'b1, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R7 generic set", match_sts, 1'b1);
        check("R7 magic untouched", magic_sts, 1'b0);
        check_all("R10 irq generic");
        do_clear(2'b01); check("R8 mask keeps match", match_sts, 1'b1);
        do_clear(2'b10); check("R8 clear match", match_sts, 1'b0);
        generic_en = 1'b0;
        fl = 0; put_junk(40);
        send_frame(1'b1, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R7 generic off", match_sts, 1'b0);

        // R9: set and clear in the same cycle.
        magic_en = 1'b1;
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
        fl = 0; put_sync(6); put_addr(16);
        send_frame(1'b1, 1'b0, 1'b1, 1'b0, 2'b01);
        check("R9 set wins", magic_sts, 1'b1);
        do_clear(2'b11);

        // Random mix covering R1..R8.
        for (int t = 0; t < 300; t++) begin
            logic crc = ($urandom_range(0, 5) != 0);
            logic am  = $urandom_range(0, 1);
            magic_en   = ($urandom_range(0, 4) != 0);
            generic_en = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) begin
                logic [47:0] a;
                for (int k = 0; k < 6; k++) a[8*k +: 8] = 8'($urandom_range(0, 254));
                station_addr = a;
            end
            fl = 0;
            put_junk($urandom_range(0, 30));
            if ($urandom_range(0, 2) != 0) begin
                put_sync($urandom_range(4, 9));
                put_addr($urandom_range(14, 16));
                if ($urandom_range(0, 4) == 0) fb[$urandom_range(0, fl - 1)] = 8'($urandom_range(0, 255));
            end
            put_junk($urandom_range(1, 30));
            send_frame(crc, am, 1'b1, 1'b1, 2'($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : 0));
            check_all("R1-mix R2 R3 R4 R6 R7");
            if ($urandom_range(0, 2) == 0) begin
                do_clear(2'($urandom_range(0, 3)));
                check_all("R8 random clear");
            end
        end
        finish_run();
    end
endmodule